// File: doc/BRIEF.md
# Three-Channel Match-Compare Timer

This peripheral holds three independent 32-bit up-counters clocked by a slow tick clock. Each counter has three comparators. A counter runs either periodically, returning to zero once it reaches the value of comparator 0, or free, wrapping only at its full width. Each comparator that meets the running count sets its own status bit. Software clears a status bit by writing a one to it, and selects through a per-timer enable mask which status bits drive that timer's interrupt line.

Software never reads a live counter. It writes to the timer's snapshot register, which sends a toggle request into the tick domain. There the count is latched and held. A returning toggle, passed through two flops, copies the held value into the bus domain. Reading the snapshot register returns the most recent completed capture. One shared register starts and stops the timers, one bit per timer.

Word address map: 0 is the run mask. Timer n occupies addresses 8·(n+1) to 8·(n+1)+6. Within that range, offsets 0, 1 and 2 are comparators 0, 1 and 2, offset 3 is the mode, offset 4 is the status, offset 5 is the interrupt enable and offset 6 is the snapshot.

Top module: `mtp_timer_top`

## Requirements
- R1: After reset, all counters, comparator values, modes, the run mask, status bits and interrupt enables are zero. Every snapshot register reads 0 and every irq line is low.
- R2: Bit n of the run mask at address 0 runs timer n. Writing 0x3 runs timers 0 and 1. Writing 0x2 then stops timer 0 while timer 1 keeps counting.
- R3: A stopped timer holds its count unchanged.
- R4: With mode bit 0 set to 1 (periodic), the tick after the count equals comparator 0 brings the count to 0. The count therefore never exceeds comparator 0, and programming N-1 gives a period of N ticks. Restarting a stopped periodic timer starts it from zero.
- R5: With mode bit 0 set to 0 (free-running), the count passes the comparator values and wraps from all ones to zero.
- R6: Status bit k of a timer sets when that timer is running and its count equals comparator k.
- R7: Writing to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A match that arrives in the same cycle as a clear leaves its bit set.
- R8: irq[n] is high exactly when some status bit of timer n has its interrupt-enable bit (same bit position) set. Enable bits of 0 mask the line.
- R9: A write to a snapshot register requests a capture. Within 40 bus cycles the register reads the count at the moment of capture. Without a request, the value read stays the same.
- R10: The comparator, mode, interrupt-enable and run-mask registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| tclk | input | 1 | Counter tick clock |
| trst | input | 1 | Synchronous active-high reset, tick domain |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe; rdata is valid on the next cycle |
| rdata | output | 32 | Registered read data |
| irq | output | 3 | Interrupt line per timer |

## Verification
A status clear written from the bus and a new comparator match can land in the same bus cycle. The bench provokes this by running a periodic timer with comparator 0 set to zero, so the timer matches on every tick. It then issues clears at a range of bus-cycle offsets, which slides each clear across the phase of the synchronised match pulses. The status bit and the interrupt must read back set after every clear, and an in-RTL property checks the same-cycle case directly.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  localparam int OFF_W = 3;
  localparam logic [OFF_W-1:0] OFF_MODE = 3'd3;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd4;
  localparam logic [OFF_W-1:0] OFF_IEN  = 3'd5;
  localparam logic [OFF_W-1:0] OFF_SNAP = 3'd6;
endpackage

// File: rtl/mtp_sync.sv
module mtp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mtp_counter.sv
module mtp_counter #(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input  logic                            tclk,
  input  logic                            trst,
  input  logic                            run_async,
  input  logic                            periodic,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]   match,
  input  logic                            req_tgl,
  output logic [NUM_CMP-1:0]              evt_tgl,
  output logic [CNT_W-1:0]                cap_val,
  output logic                            ack_tgl
);
  logic run_s, run_d, req_s, restart;
  logic [CNT_W-1:0] count;
  logic [NUM_CMP-1:0] hit;

  mtp_sync #(.W(2)) u_sync (
    .clk(tclk), .rst(trst),
    .d({run_async, req_tgl}), .q({run_s, req_s})
  );

  assign restart = run_s && !run_d && periodic;

  always_comb begin
    for (int k = 0; k < NUM_CMP; k++)
      hit[k] = run_s && !restart && (count == match[k]);
  end

  always_ff @(posedge tclk) begin
    if (trst) begin
      run_d   <= 1'b0;
      count   <= '0;
      evt_tgl <= '0;
      cap_val <= '0;
      ack_tgl <= 1'b0;
    end else begin
      run_d <= run_s;
      if (restart)
        count <= '0;
      else if (run_s) begin
        if (periodic && count == match[0])
          count <= '0;
        else
          count <= count + 1'b1;
      end
      evt_tgl <= evt_tgl ^ hit;
      if (req_s != ack_tgl) begin
        cap_val <= count;
        ack_tgl <= req_s;
      end
    end
  end

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge tclk) disable iff (trst)
    !run_s |=> $stable(count)); // R3
  AST_PERIODIC_RELOAD: assert property (@(posedge tclk) disable iff (trst)
    (run_s && run_d && periodic && count == match[0]) |=> (count == '0)); // R4
  AST_PERIODIC_RESTART: assert property (@(posedge tclk) disable iff (trst)
    ($rose(run_s) && periodic) |=> (count == '0)); // R4
  AST_FREE_WRAP: assert property (@(posedge tclk) disable iff (trst)
    (run_s && !periodic && (&count)) |=> (count == '0)); // R5
endmodule

// File: rtl/mtp_chan.sv
module mtp_chan
  import mtp_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CMP = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sel,
  input  logic [OFF_W-1:0]              off,
  input  logic                          wr,
  input  logic [CNT_W-1:0]              wdata,
  input  logic [NUM_CMP-1:0]            evt_tgl,
  input  logic [CNT_W-1:0]              cap_val,
  input  logic                          ack_tgl,
  output logic [NUM_CMP-1:0][CNT_W-1:0] match,
  output logic                          periodic,
  output logic                          req_tgl,
  output logic                          irq,
  output logic [CNT_W-1:0]              rd_val
);
  logic [NUM_CMP-1:0] evt_s, evt_d, evt, stat, ien, clr_mask;
  logic ack_s, ack_d, ack_pulse;
  logic [CNT_W-1:0] snap;
  logic wr_here;

  mtp_sync #(.W(NUM_CMP + 1)) u_sync (
    .clk(clk), .rst(rst),
    .d({evt_tgl, ack_tgl}), .q({evt_s, ack_s})
  );

  assign wr_here   = wr && sel;
  assign evt       = evt_s ^ evt_d;
  assign ack_pulse = ack_s ^ ack_d;
  assign clr_mask  = (wr_here && off == OFF_STAT) ? wdata[NUM_CMP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      match    <= '0;
      periodic <= 1'b0;
      ien      <= '0;
      stat     <= '0;
      evt_d    <= '0;
      ack_d    <= 1'b0;
      req_tgl  <= 1'b0;
      snap     <= '0;
      irq      <= 1'b0;
    end else begin
      for (int k = 0; k < NUM_CMP; k++)
        if (wr_here && off == OFF_W'(k)) match[k] <= wdata;
      if (wr_here && off == OFF_MODE) periodic <= wdata[0];
      if (wr_here && off == OFF_IEN)  ien <= wdata[NUM_CMP-1:0];
      if (wr_here && off == OFF_SNAP) req_tgl <= ~req_tgl;
      evt_d <= evt_s;
      ack_d <= ack_s;
      stat  <= (stat & ~clr_mask) | evt;
      if (ack_pulse) snap <= cap_val;
      irq <= |(stat & ien);
    end
  end

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_CMP; k++)
      if (off == OFF_W'(k)) rd_val = match[k];
    case (off)
      OFF_MODE: rd_val = CNT_W'(periodic);
      OFF_STAT: rd_val = CNT_W'(stat);
      OFF_IEN:  rd_val = CNT_W'(ien);
      OFF_SNAP: rd_val = snap;
      default: ;
    endcase
  end

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_mask != '0) |=> ((stat & $past(clr_mask & ~evt)) == '0)); // R7
  AST_MATCH_WINS: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt))); // R7
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ack_pulse |=> $stable(snap)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ien == '0 && $past(ien) == '0) |-> !irq); // R8
endmodule

// File: rtl/mtp_timer_top.sv
module mtp_timer_top
  import mtp_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int NUM_CMP    = 3,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tclk,
  input  logic                  trst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CNT_W-1:0]      wdata,
  input  logic                  wr,
  input  logic                  rd,
  output logic [CNT_W-1:0]      rdata,
  output logic [NUM_TIMERS-1:0] irq
);
  localparam int SEL_W = ADDR_W - OFF_W;

  logic [NUM_TIMERS-1:0] run_mask;
  logic [NUM_TIMERS-1:0][CNT_W-1:0] ch_rd;
  logic [SEL_W-1:0] page;
  logic [CNT_W-1:0] rd_mux;

  assign page = addr[ADDR_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (rst)
      run_mask <= '0;
    else if (wr && addr == '0)
      run_mask <= wdata[NUM_TIMERS-1:0];
  end

  for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_timer
    logic [NUM_CMP-1:0][CNT_W-1:0] match;
    logic [NUM_CMP-1:0] evt_tgl;
    logic [CNT_W-1:0] cap_val;
    logic periodic, req_tgl, ack_tgl;

    mtp_chan #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_chan (
      .clk(clk), .rst(rst),
      .sel(page == SEL_W'(n + 1)), .off(addr[OFF_W-1:0]),
      .wr(wr), .wdata(wdata),
      .evt_tgl(evt_tgl), .cap_val(cap_val), .ack_tgl(ack_tgl),
      .match(match), .periodic(periodic), .req_tgl(req_tgl),
      .irq(irq[n]), .rd_val(ch_rd[n])
    );

    mtp_counter #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_cnt (
      .tclk(tclk), .trst(trst),
      .run_async(run_mask[n]), .periodic(periodic), .match(match),
      .req_tgl(req_tgl), .evt_tgl(evt_tgl),
      .cap_val(cap_val), .ack_tgl(ack_tgl)
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr == '0) rd_mux = CNT_W'(run_mask);
    for (int n = 0; n < NUM_TIMERS; n++)
      if (page == SEL_W'(n + 1)) rd_mux = ch_rd[n];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= rd_mux;
  end

  AST_RUN_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == '0) |=> (run_mask == $past(wdata[NUM_TIMERS-1:0]))); // R2
endmodule

// File: tb/mtp_timer_top_tb_top.sv
`timescale 1ns/1ps
module mtp_timer_top_tb_top;
  logic clk = 0, tclk = 0, rst = 1, trst = 1;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic wr = 0, rd = 0;
  logic [31:0] rdata;
  logic [2:0] irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always #17 tclk = ~tclk;

  mtp_timer_top dut_i (
    .clk(clk), .rst(rst), .tclk(tclk), .trst(trst),
    .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .irq(irq)
  );

  function automatic logic [5:0] ra(int t, int off);
    return 6'((t + 1) * 8 + off);
  endfunction

  task automatic check(string tag, logic ok, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1;
    @(posedge clk); #1;
    wr = 0;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    addr = a; rd = 1;
    @(posedge clk); #1;
    rd = 0;
    d = rdata;
  endtask

  task automatic snap(int t, output logic [31:0] v);
    bus_wr(ra(t, 6), 0);
    repeat (40) @(posedge clk);
    bus_rd(ra(t, 6), v);
  endtask

  task automatic ticks(int n);
    repeat (n) @(posedge tclk);
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(0, v);        check("R1 run mask", v == 0, v, 0);
    bus_rd(ra(0, 4), v); check("R1 status", v == 0, v, 0);
    bus_rd(ra(1, 6), v); check("R1 snapshot", v == 0, v, 0);
    bus_rd(ra(2, 1), v); check("R1 comparator", v == 0, v, 0);
    check("R1 irq", irq == 0, 32'(irq), 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    bus_wr(ra(2, 0), 32'hDEAD_0001);
    bus_wr(ra(2, 2), 32'h1234_5678);
    bus_wr(ra(2, 3), 1);
    bus_wr(ra(2, 5), 5);
    bus_rd(ra(2, 0), v); check("R10 cmp0", v == 32'hDEAD_0001, v, 32'hDEAD_0001);
    bus_rd(ra(2, 2), v); check("R10 cmp2", v == 32'h1234_5678, v, 32'h1234_5678);
    bus_rd(ra(2, 3), v); check("R10 mode", v == 1, v, 1);
    bus_rd(ra(2, 5), v); check("R10 ien", v == 5, v, 5);
    bus_wr(ra(2, 5), 0);
    bus_wr(ra(2, 3), 0);
  endtask

  task automatic t_free;
    logic [31:0] v;
    bus_wr(ra(1, 0), 20);
    bus_wr(ra(1, 1), 30);
    bus_wr(ra(1, 2), 40);
    bus_wr(0, 2);
    bus_rd(0, v); check("R10 run mask", v == 2, v, 2);
    ticks(100);
    snap(1, v);   check("R5 runs past cmp", v > 40, v, 41);
    bus_rd(ra(1, 4), v); check("R6 all matched", v == 7, v, 7);
    check("R8 masked", irq[1] == 0, 32'(irq[1]), 0);
    bus_wr(ra(1, 5), 2);
    repeat (3) @(posedge clk); #1;
    check("R8 enabled", irq[1] == 1, 32'(irq[1]), 1);
    bus_wr(ra(1, 4), 2);
    bus_rd(ra(1, 4), v); check("R7 clear one", v == 5, v, 5);
    repeat (3) @(posedge clk); #1;
    check("R8 drops", irq[1] == 0, 32'(irq[1]), 0);
    bus_wr(ra(1, 4), 0);
    bus_rd(ra(1, 4), v); check("R7 zero write", v == 5, v, 5);
  endtask

  task automatic t_periodic;
    logic [31:0] v, a, b;
    bus_wr(ra(0, 0), 9);
    bus_wr(ra(0, 1), 5);
    bus_wr(ra(0, 2), 7);
    bus_wr(ra(0, 3), 1);
    snap(1, a);
    bus_wr(0, 3);
    ticks(30);
    for (int i = 0; i < 5; i++) begin
      snap(0, v);
      check("R4 bounded by cmp0", v <= 9, v, 9);
      ticks(i + 1);
    end
    bus_rd(ra(0, 4), v); check("R6 periodic matches", v == 7, v, 7);
    snap(1, b);   check("R2 timer1 running", b > a, b, a + 1);
  endtask

  task automatic t_stop;
    logic [31:0] a, b, c, d;
    bus_wr(0, 2);
    ticks(10);
    snap(0, a);
    snap(1, c);
    ticks(50);
    snap(0, b);   check("R3 held", a == b, b, a);
    snap(1, d);   check("R2 other runs", d > c, d, c + 1);
  endtask

  task automatic t_restart;
    logic [31:0] v, u;
    bus_wr(ra(0, 0), 100000);
    bus_wr(0, 3);
    ticks(300);
    bus_wr(0, 2);
    ticks(10);
    snap(0, v);   check("R9 capture large", v > 250, v, 250);
    bus_wr(0, 3);
    ticks(10);
    snap(0, u);   check("R4 restart from zero", u < 50, u, 0);
    bus_rd(ra(0, 6), v); check("R9 no request stable", v == u, v, u);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    bus_wr(ra(2, 0), 0);
    bus_wr(ra(2, 3), 1);
    bus_wr(ra(2, 5), 1);
    bus_wr(0, 7);
    ticks(10);
    for (int i = 0; i < 8; i++) begin
      repeat (i) @(posedge clk);
      bus_wr(ra(2, 4), 1);
      repeat (20) @(posedge clk);
      bus_rd(ra(2, 4), v);
      check("R7 match wins clear", v[0] == 1, 32'(v[0]), 1);
      check("R8 irq stays", irq[2] == 1, 32'(irq[2]), 1);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge tclk);
    @(posedge clk); #1;
    rst = 0;
    @(posedge tclk); #1;
    trst = 0;
    repeat (4) @(posedge clk); #1;
    t_reset;
    t_regs;
    t_free;
    t_periodic;
    t_stop;
    t_restart;
    t_collide;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule